// File: doc/BRIEF.md
# Fault Snapshot Recorder

This block keeps a black-box record of power faults. When a fault event arrives it takes a snapshot. The snapshot holds the time of the event from a free-running counter and the rail number. It also holds the fault class, the voltage, current and temperature codes, the power-good level, the sequencer step and the retry count. The snapshot is stored in an on-chip circular log that stands in for non-volatile storage.

Classes marked critical go to the log at once. Routine classes wait in a small staging queue, which is committed in a burst when it fills or when a batch timer runs out. A power-loss input forces the queue out early. A write-protect input stops every log write. Events that arrive while write-protect is high are counted rather than kept. A host reads any slot by index. The write pointer and a wrap flag show how far the log has filled.

Top module: `fault_event_logger`

## Requirements
- R1: After reset the write pointer is 0, the wrap flag is 0 and the dropped-event count is 0.
- R2: A stored slot returns every field exactly as it was presented with the event. The class codes are over-voltage 0, under-voltage 1, over-current 2, over-temperature 3 and watchdog 4.
- R3: The timestamp counter is 0 out of reset and then rises by one on every clock. An entry stores the counter value of the cycle in which its event was sampled, so the gap between two entries equals the cycle gap between their events.
- R4: Critical classes are written straight through, and the write pointer has moved one clock after the event. With the default mask, codes 0, 2 and 4 and the reserved codes 5 to 7 are critical.
- R5: Routine classes (codes 1 and 3 by default) are staged, and the write pointer does not move when such an event arrives.
- R6: When the staging queue reaches STAGE_DEPTH entries, the queue is committed starting on the next clock. The commits come one per clock, in arrival order.
- R7: A lone staged entry is committed TIMEOUT+1 clocks after its event, and no earlier.
- R8: A critical event takes the single write slot ahead of a queue being committed. The burst then resumes on the following clock, so the critical entry lands first.
- R9: Power loss, when sampled high, starts committing every staged entry on the next clock, one per clock.
- R10: While write-protect is high, no slot is written and the pointer holds, even after power loss or timer expiry. Each event that arrives is dropped and adds one to a saturating drop count. Staged entries are kept and begin committing on the first clock after write-protect falls.
- R11: After slot LOG_DEPTH-1 is written, the pointer returns to 0 and the next entry overwrites the oldest slot. The wrap flag becomes 1 and stays 1. LOG_DEPTH must be a power of two.
- R12: The read outputs show the contents of the slot selected by the read index, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_valid | input | 1 | Fault event present this cycle |
| ev_class | input | 3 | Fault class code |
| ev_rail | input | 4 | Rail number |
| ev_volt | input | 12 | Voltage code |
| ev_curr | input | 12 | Current code |
| ev_temp | input | 12 | Temperature code |
| ev_pgood | input | 1 | Power-good level |
| ev_step | input | 4 | Sequencer step |
| ev_retry | input | 3 | Retry count |
| wr_protect | input | 1 | High blocks all log writes |
| pwr_loss | input | 1 | High forces the staging queue out |
| rd_idx | input | 4 | Slot to read |
| rd_ts | output | 32 | Timestamp of selected slot |
| rd_rail | output | 4 | Rail of selected slot |
| rd_class | output | 3 | Class of selected slot |
| rd_volt | output | 12 | Voltage of selected slot |
| rd_curr | output | 12 | Current of selected slot |
| rd_temp | output | 12 | Temperature of selected slot |
| rd_pgood | output | 1 | Power-good of selected slot |
| rd_step | output | 4 | Sequencer step of selected slot |
| rd_retry | output | 3 | Retry count of selected slot |
| wr_ptr | output | 4 | Next slot to be written |
| wrapped | output | 1 | Log has rolled over at least once |
| drop_count | output | 8 | Events dropped under write-protect |

## Verification
A critical event is due in the log one clock after the edge that samples it. A staged burst begins one clock after the queue fills or power loss is sampled, and then moves one slot per clock. A lone routine entry is due TIMEOUT+1 clocks after its event. The bench drives at falling edges and counts whole clocks from the sampling edge before each check. It tests the pointer both one clock before and at the clock a commit is due, so an early or late commit is caught. Read data is sampled a short delay after the index changes.

// File: rtl/flt_log_pkg.sv
package flt_log_pkg;
    localparam int TS_W    = 32;
    localparam int RAIL_W  = 4;
    localparam int CLS_W   = 3;
    localparam int MEAS_W  = 12;
    localparam int STEP_W  = 4;
    localparam int RETRY_W = 3;
    localparam int DROP_W  = 8;

    typedef enum logic [CLS_W-1:0] {
        EV_OVERVOLT  = 3'd0,
        EV_UNDERVOLT = 3'd1,
        EV_OVERCURR  = 3'd2,
        EV_OVERTEMP  = 3'd3,
        EV_WDOG      = 3'd4
    } ev_class_e;

    typedef struct packed {
        logic [TS_W-1:0]    ts;
        logic [RAIL_W-1:0]  rail;
        logic [CLS_W-1:0]   cls;
        logic [MEAS_W-1:0]  volt;
        logic [MEAS_W-1:0]  curr;
        logic [MEAS_W-1:0]  temp;
        logic               pgood;
        logic [STEP_W-1:0]  step;
        logic [RETRY_W-1:0] retry;
    } snap_t;
endpackage

// File: rtl/flt_stage.sv
module flt_stage
    import flt_log_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int TIMEOUT = 64,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int TW     = $clog2(TIMEOUT + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  snap_t push_data,
    input  logic  pwr_loss,
    input  logic  drain_ack,
    output logic  drain_req,
    output snap_t drain_data
);
    typedef struct packed {
        snap_t [DEPTH-1:0] slots;
        logic [PW-1:0]     rp;
        logic [PW-1:0]     wp;
        logic [CNT_W-1:0]  cnt;
        logic [TW-1:0]     tmr;
        logic              flush;
    } stage_t;

    stage_t s_d, s_q;
    logic pop, push_ok;

    always_comb begin
        s_d     = s_q;
        pop     = drain_ack && s_q.flush && (s_q.cnt != '0);
        push_ok = push && ((s_q.cnt != CNT_W'(DEPTH)) || pop);
        if (push_ok) begin
            s_d.slots[s_q.wp] = push_data;
            s_d.wp = (s_q.wp == PW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        end
        if (pop) begin
            s_d.rp = (s_q.rp == PW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        end
        case ({push_ok, pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
        if (s_d.cnt == '0) begin
            s_d.tmr   = '0;
            s_d.flush = 1'b0;
        end else begin
            if ((s_q.cnt != '0) && !s_q.flush && (s_q.tmr != TW'(TIMEOUT)))
                s_d.tmr = s_q.tmr + 1'b1;
            s_d.flush = s_q.flush || (s_d.cnt == CNT_W'(DEPTH)) ||
                        (s_d.tmr >= TW'(TIMEOUT)) || pwr_loss;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign drain_req  = s_q.flush && (s_q.cnt != '0);
    assign drain_data = s_q.slots[s_q.rp];

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));

    assert_full_flushes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_W'(DEPTH)) |-> drain_req);

    assert_pwrloss_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_loss && (s_q.cnt != '0) && !drain_ack) |=> drain_req);
endmodule

// File: rtl/flt_store.sv
module flt_store
    import flt_log_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  snap_t            wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output snap_t            rdata,
    output logic [IDX_W-1:0] wr_ptr,
    output logic             wrapped
);
    typedef struct packed {
        snap_t [DEPTH-1:0] mem;
        logic [IDX_W-1:0]  ptr;
        logic              wrap;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            s_d.mem[s_q.ptr] = wdata;
            if (s_q.ptr == IDX_W'(DEPTH - 1)) begin
                s_d.ptr  = '0;
                s_d.wrap = 1'b1;
            end else begin
                s_d.ptr = s_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata   = s_q.mem[rd_idx];
    assign wr_ptr  = s_q.ptr;
    assign wrapped = s_q.wrap;

    assert_wrap_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped |=> wrapped);

    assert_wrap_point_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wr_ptr == IDX_W'(DEPTH - 1))) |=> ((wr_ptr == '0) && wrapped));
endmodule

// File: rtl/fault_event_logger.sv
module fault_event_logger
    import flt_log_pkg::*;
#(
    parameter int          LOG_DEPTH   = 16,
    parameter int          STAGE_DEPTH = 4,
    parameter int          TIMEOUT     = 64,
    parameter logic [7:0]  CRIT_MASK   = 8'hF5,
    localparam int         IDX_W       = $clog2(LOG_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_valid,
    input  logic [CLS_W-1:0]   ev_class,
    input  logic [RAIL_W-1:0]  ev_rail,
    input  logic [MEAS_W-1:0]  ev_volt,
    input  logic [MEAS_W-1:0]  ev_curr,
    input  logic [MEAS_W-1:0]  ev_temp,
    input  logic               ev_pgood,
    input  logic [STEP_W-1:0]  ev_step,
    input  logic [RETRY_W-1:0] ev_retry,
    input  logic               wr_protect,
    input  logic               pwr_loss,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [TS_W-1:0]    rd_ts,
    output logic [RAIL_W-1:0]  rd_rail,
    output logic [CLS_W-1:0]   rd_class,
    output logic [MEAS_W-1:0]  rd_volt,
    output logic [MEAS_W-1:0]  rd_curr,
    output logic [MEAS_W-1:0]  rd_temp,
    output logic               rd_pgood,
    output logic [STEP_W-1:0]  rd_step,
    output logic [RETRY_W-1:0] rd_retry,
    output logic [IDX_W-1:0]   wr_ptr,
    output logic               wrapped,
    output logic [DROP_W-1:0]  drop_count
);
    typedef struct packed {
        logic [TS_W-1:0]   ts;
        logic [DROP_W-1:0] drop;
    } top_t;

    top_t  t_d, t_q;
    snap_t ev_snap, drain_data, log_data, rdata;
    logic  is_crit, crit_now, drain_req, drain_ack, stage_push, log_we;

    always_comb begin
        ev_snap = '{ts: t_q.ts, rail: ev_rail, cls: ev_class, volt: ev_volt,
                    curr: ev_curr, temp: ev_temp, pgood: ev_pgood,
                    step: ev_step, retry: ev_retry};
        is_crit    = CRIT_MASK[ev_class];
        crit_now   = ev_valid && is_crit && !wr_protect;
        stage_push = ev_valid && !is_crit && !wr_protect;
        drain_ack  = drain_req && !wr_protect && !crit_now;
        log_we     = crit_now || drain_ack;
        log_data   = crit_now ? ev_snap : drain_data;

        t_d    = t_q;
        t_d.ts = t_q.ts + 1'b1;
        if (ev_valid && wr_protect && (t_q.drop != '1))
            t_d.drop = t_q.drop + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    flt_stage #(.DEPTH(STAGE_DEPTH), .TIMEOUT(TIMEOUT)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (stage_push),
        .push_data  (ev_snap),
        .pwr_loss   (pwr_loss),
        .drain_ack  (drain_ack),
        .drain_req  (drain_req),
        .drain_data (drain_data)
    );

    flt_store #(.DEPTH(LOG_DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (log_we),
        .wdata   (log_data),
        .rd_idx  (rd_idx),
        .rdata   (rdata),
        .wr_ptr  (wr_ptr),
        .wrapped (wrapped)
    );

    assign rd_ts      = rdata.ts;
    assign rd_rail    = rdata.rail;
    assign rd_class   = rdata.cls;
    assign rd_volt    = rdata.volt;
    assign rd_curr    = rdata.curr;
    assign rd_temp    = rdata.temp;
    assign rd_pgood   = rdata.pgood;
    assign rd_step    = rdata.step;
    assign rd_retry   = rdata.retry;
    assign drop_count = t_q.drop;

    assert_ts_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.ts != '1) |=> (t_q.ts == $past(t_q.ts) + 1'b1));

    assert_crit_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && is_crit && !wr_protect) |=> (wr_ptr == IDX_W'($past(wr_ptr) + 1'b1)));

    assert_routine_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !is_crit && !drain_req) |=> (wr_ptr == $past(wr_ptr)));

    assert_wp_no_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_protect |=> (wr_ptr == $past(wr_ptr)));

    assert_drop_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && wr_protect && (drop_count != '1)) |=> (drop_count == $past(drop_count) + 1'b1));
endmodule

// File: tb/sim_fault_event_logger.sv
module sim_fault_event_logger;
    import flt_log_pkg::*;

    localparam int TMO = 64;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst_n, ev_valid, ev_pgood, wr_protect, pwr_loss;
    logic [CLS_W-1:0]   ev_class;
    logic [RAIL_W-1:0]  ev_rail;
    logic [MEAS_W-1:0]  ev_volt, ev_curr, ev_temp;
    logic [STEP_W-1:0]  ev_step;
    logic [RETRY_W-1:0] ev_retry;
    logic [3:0]         rd_idx;
    logic [TS_W-1:0]    rd_ts;
    logic [RAIL_W-1:0]  rd_rail;
    logic [CLS_W-1:0]   rd_class;
    logic [MEAS_W-1:0]  rd_volt, rd_curr, rd_temp;
    logic               rd_pgood, wrapped;
    logic [STEP_W-1:0]  rd_step;
    logic [RETRY_W-1:0] rd_retry;
    logic [3:0]         wr_ptr;
    logic [DROP_W-1:0]  drop_count;

    fault_event_logger u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_class(ev_class),
        .ev_rail(ev_rail), .ev_volt(ev_volt), .ev_curr(ev_curr), .ev_temp(ev_temp),
        .ev_pgood(ev_pgood), .ev_step(ev_step), .ev_retry(ev_retry),
        .wr_protect(wr_protect), .pwr_loss(pwr_loss), .rd_idx(rd_idx),
        .rd_ts(rd_ts), .rd_rail(rd_rail), .rd_class(rd_class), .rd_volt(rd_volt),
        .rd_curr(rd_curr), .rd_temp(rd_temp), .rd_pgood(rd_pgood), .rd_step(rd_step),
        .rd_retry(rd_retry), .wr_ptr(wr_ptr), .wrapped(wrapped), .drop_count(drop_count)
    );

    int cyc = 0;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ptr = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] cls, input logic [11:0] volt, output int ts);
        ev_valid = 1'b1; ev_class = cls; ev_volt = volt;
        ev_rail = volt[3:0]; ev_curr = volt ^ 12'hA5A; ev_temp = volt + 12'd7;
        ev_pgood = volt[0]; ev_step = volt[7:4]; ev_retry = volt[2:0];
        ts = cyc;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_slot(string req, input int idx, input logic [2:0] cls, input logic [11:0] volt);
        rd_idx = 4'(idx);
        #1;
        chk(req, rd_class, cls);
        chk(req, rd_volt, volt);
    endtask

    task automatic t_reset_R1();
        chk("R1 wr_ptr", wr_ptr, 0);
        chk("R1 wrapped", wrapped, 0);
        chk("R1 drop", drop_count, 0);
    endtask

    task automatic t_crit_R2_R3_R4();
        int ts_a, ts_b;
        send(3'd0, 12'h3C3, ts_a);
        exp_ptr++;
        chk("R4 ptr after critical", wr_ptr, exp_ptr);
        rd_idx = 4'd0;
        #1;
        chk("R2 class", rd_class, 0);
        chk("R2 rail", rd_rail, 4'h3);
        chk("R2 volt", rd_volt, 12'h3C3);
        chk("R2 curr", rd_curr, 12'h3C3 ^ 12'hA5A);
        chk("R2 temp", rd_temp, 12'h3CA);
        chk("R2 pgood", rd_pgood, 1'b1);
        chk("R2 step", rd_step, 4'hC);
        chk("R2 retry", rd_retry, 3'd3);
        chk("R3 absolute ts", rd_ts, ts_a);
        wait_cyc(4);
        send(3'd2, 12'h3D0, ts_b);
        exp_ptr++;
        chk("R4 ptr after second critical", wr_ptr, exp_ptr);
        rd_idx = 4'd1;
        #1;
        chk("R3 ts gap", rd_ts - 32'(ts_a), 5);
        chk("R12 read slot1 class", rd_class, 2);
    endtask

    task automatic t_batch_full_R5_R6();
        int ts;
        int base = exp_ptr;
        for (int i = 0; i < 4; i++) send((i % 2 == 0) ? 3'd1 : 3'd3, 12'h101 + 12'(i), ts);
        chk("R5 routine staged, ptr held", wr_ptr, base);
        wait_cyc(1);
        chk("R6 first burst commit", wr_ptr, base + 1);
        wait_cyc(3);
        chk("R6 burst done", wr_ptr, base + 4);
        exp_ptr = base + 4;
        for (int i = 0; i < 4; i++)
            check_slot("R6 order", base + i, (i % 2 == 0) ? 3'd1 : 3'd3, 12'h101 + 12'(i));
    endtask

    task automatic t_timer_R7();
        int ts;
        int base = exp_ptr;
        send(3'd3, 12'h2B0, ts);
        wait_cyc(TMO);
        chk("R7 not before timeout", wr_ptr, base);
        wait_cyc(1);
        chk("R7 commit at timeout", wr_ptr, base + 1);
        exp_ptr = base + 1;
        check_slot("R7 slot", base, 3'd3, 12'h2B0);
    endtask

    task automatic t_crit_preempt_R8();
        int ts;
        int base = exp_ptr;
        for (int i = 0; i < 4; i++) send(3'd1, 12'h501 + 12'(i), ts);
        send(3'd4, 12'h5F0, ts);
        chk("R8 critical first", wr_ptr, base + 1);
        wait_cyc(4);
        chk("R8 burst resumes", wr_ptr, base + 5);
        exp_ptr = base + 5;
        check_slot("R8 critical slot", base, 3'd4, 12'h5F0);
        for (int i = 0; i < 4; i++) check_slot("R8 routine slot", base + 1 + i, 3'd1, 12'h501 + 12'(i));
    endtask

    task automatic t_pwrloss_R9();
        int ts;
        int base = exp_ptr;
        send(3'd1, 12'h601, ts);
        send(3'd3, 12'h602, ts);
        pwr_loss = 1'b1;
        @(negedge clk);
        pwr_loss = 1'b0;
        chk("R9 not yet", wr_ptr, base);
        wait_cyc(1);
        chk("R9 first flush", wr_ptr, base + 1);
        wait_cyc(1);
        chk("R9 flush done", wr_ptr, base + 2);
        exp_ptr = base + 2;
        check_slot("R9 slot", base + 1, 3'd3, 12'h602);
    endtask

    task automatic t_wp_R10();
        int ts;
        int base = exp_ptr;
        send(3'd1, 12'h701, ts);
        wr_protect = 1'b1;
        send(3'd0, 12'h7E0, ts);
        chk("R10 critical blocked", wr_ptr, base);
        send(3'd3, 12'h7E1, ts);
        chk("R10 drop count", drop_count, 2);
        pwr_loss = 1'b1;
        @(negedge clk);
        pwr_loss = 1'b0;
        wait_cyc(TMO + 6);
        chk("R10 held under protect", wr_ptr, base);
        wr_protect = 1'b0;
        @(negedge clk);
        chk("R10 commit after release", wr_ptr, base + 1);
        exp_ptr = base + 1;
        check_slot("R10 kept entry", base, 3'd1, 12'h701);
        wait_cyc(2);
        chk("R10 dropped not stored", wr_ptr, base + 1);
    endtask

    task automatic t_rollover_R11();
        int ts;
        chk("R11 pre-wrap ptr", wr_ptr, 15);
        chk("R11 pre-wrap flag", wrapped, 0);
        send(3'd0, 12'h9A1, ts);
        chk("R11 ptr wraps", wr_ptr, 0);
        chk("R11 wrap flag", wrapped, 1);
        check_slot("R11 last slot", 15, 3'd0, 12'h9A1);
        send(3'd2, 12'h9A2, ts);
        check_slot("R11 oldest overwritten", 0, 3'd2, 12'h9A2);
        chk("R11 ptr after overwrite", wr_ptr, 1);
        chk("R11 flag sticky", wrapped, 1);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ev_valid = 1'b0; ev_class = '0; ev_rail = '0; ev_volt = '0;
        ev_curr = '0; ev_temp = '0; ev_pgood = 1'b0; ev_step = '0; ev_retry = '0;
        wr_protect = 1'b0; pwr_loss = 1'b0; rd_idx = '0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset_R1();
        t_crit_R2_R3_R4();
        t_batch_full_R5_R6();
        t_timer_R7();
        t_crit_preempt_R8();
        t_pwrloss_R9();
        t_wp_R10();
        t_rollover_R11();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule